// File: doc/BRIEF.md
# Filtered High-Side Undervoltage Lockout

This block decides when the floating high-side supply of a half-bridge gate driver is too low to use, and blocks the high-side gate command while it is. Two comparator flags feed it. `uv_trip` says the supply is below the trip level. `uv_clear` says the supply is above the higher release level. A short dip below the trip level is ignored. The block locks only if the trip flag stays high for more than `FILT_CYC` consecutive clock cycles.

While the block is locked, the high-side output is held low. Lockout ends when the release flag is seen with the trip flag low. After that the high side stays off until the high command shows a new rising edge, so a command that was already high is not passed on. The low-side command goes straight through, one cycle late, whatever the lockout state. The block comes out of reset in the locked state.

Top module: `hs_uvlo_gate`

## Requirements
- R1: `uv_locked` rises on the clock edge that samples `uv_trip`=1 with `uv_clear`=0 for the (FILT_CYC+1)th consecutive cycle. After FILT_CYC such cycles it is still 0.
- R2: A cycle with `uv_trip`=0 while unlocked resets the run count. Trip runs of FILT_CYC cycles or fewer, separated by such cycles, never cause lockout.
- R3: While locked, a clock edge that samples `uv_clear`=1 and `uv_trip`=0 clears `uv_locked` at that edge.
- R4: `hi_out` is 0 in every cycle where `uv_locked` is 1. The edge that sets the lockout also forces `hi_out` to 0.
- R5: After release, and after reset, `hi_out` stays 0 until a rising edge of `hi_cmd` is sampled while unlocked. A command held high through release gives no output. Once enabled, `hi_out` follows `hi_cmd` one cycle late.
- R6: `lo_out` equals `lo_cmd` delayed by one cycle, whether or not the block is locked.
- R7: A cycle with both `uv_trip` and `uv_clear` at 1 changes neither the lockout state nor the run count.
- R8: During and right after reset, `uv_locked`=1, `hi_out`=0 and `lo_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uv_trip | input | 1 | Supply is below the trip level |
| uv_clear | input | 1 | Supply is above the release level |
| hi_cmd | input | 1 | High-side gate command |
| lo_cmd | input | 1 | Low-side gate command |
| uv_locked | output | 1 | Lockout is active |
| hi_out | output | 1 | Gated high-side command, registered |
| lo_out | output | 1 | Low-side command, registered |

## Verification
The bench checks the filter at its exact boundary. After FILT_CYC trip cycles the block must still be unlocked, and it must lock one cycle later. A counter off by one fails one of these two checks. Trip runs broken by a single clear cycle catch a counter that never resets and so locks on scattered dips. Holding the high command high through a release catches a gate that reopens without waiting for a fresh edge. Driving both flags together, while locked and while counting, catches a design that lets either flag win a conflict. The low side is toggled during lockout to show it is never gated.

// File: rtl/hs_uvlo_gate.sv
module hs_uvlo_gate #(
  parameter int FILT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_trip,
  input  logic uv_clear,
  input  logic hi_cmd,
  input  logic lo_cmd,
  output logic uv_locked,
  output logic hi_out,
  output logic lo_out
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(FILT_CYC);

  logic [CW-1:0] run_cnt;
  logic locked, armed, hi_q, hi_prev, lo_q;

  wire conflict = uv_trip && uv_clear;
  wire lock_set = !locked && uv_trip && !uv_clear && (run_cnt == CMAX);
  wire hi_rise  = hi_cmd && !hi_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b1;
      run_cnt <= '0;
    end else if (!conflict) begin
      if (locked) begin
        run_cnt <= '0;
        if (uv_clear) locked <= 1'b0;
      end else if (uv_trip) begin
        if (run_cnt == CMAX) locked <= 1'b1;
        else run_cnt <= run_cnt + 1'b1;
      end else begin
        run_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      hi_q    <= 1'b0;
      hi_prev <= 1'b0;
      lo_q    <= 1'b0;
    end else begin
      hi_prev <= hi_cmd;
      lo_q    <= lo_cmd;
      if (locked || lock_set) begin
        armed <= 1'b0;
        hi_q  <= 1'b0;
      end else if (armed) begin
        hi_q <= hi_cmd;
      end else if (hi_rise) begin
        armed <= 1'b1;
        hi_q  <= 1'b1;
      end
    end
  end

  assign uv_locked = locked;
  assign hi_out    = hi_q;
  assign lo_out    = lo_q;
endmodule

module hs_uvlo_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic uv_trip,
  input logic uv_clear,
  input logic hi_cmd,
  input logic lo_cmd,
  input logic uv_locked,
  input logic hi_out,
  input logic lo_out
);
  assert_lock_needs_trip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_locked) |-> $past(uv_trip && !uv_clear));
  assert_release_needs_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uv_locked) |-> $past(uv_clear && !uv_trip));
  assert_locked_forces_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    uv_locked |-> !hi_out);
  assert_hi_needs_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_out) |-> $past(hi_cmd));
  assert_lo_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lo_out == $past(lo_cmd)));
  assert_conflict_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_trip && uv_clear) |=> $stable(uv_locked));
endmodule

bind hs_uvlo_gate hs_uvlo_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uv_trip(uv_trip), .uv_clear(uv_clear),
  .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .uv_locked(uv_locked),
  .hi_out(hi_out), .lo_out(lo_out)
);

// File: tb/hs_uvlo_gate_test.sv
module hs_uvlo_gate_test;
  localparam int F = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic uv_trip = 1'b0, uv_clear = 1'b0, hi_cmd = 1'b0, lo_cmd = 1'b0;
  logic uv_locked, hi_out, lo_out;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hs_uvlo_gate #(.FILT_CYC(F)) uut (
    .clk(clk), .rst_n(rst_n), .uv_trip(uv_trip), .uv_clear(uv_clear),
    .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .uv_locked(uv_locked),
    .hi_out(hi_out), .lo_out(lo_out)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  task automatic t_reset();
    hi_cmd = 1'b1; lo_cmd = 1'b1;
    tick(2);
    chk("R8", "locked in reset", uv_locked, 1'b1);
    chk("R8", "hi_out in reset", hi_out, 1'b0);
    chk("R8", "lo_out in reset", lo_out, 1'b0);
    rst_n = 1'b1;
    tick(3);
    chk("R8", "locked after reset", uv_locked, 1'b1);
    chk("R4", "hi low while locked", hi_out, 1'b0);
    lo_cmd = 1'b0;
  endtask

  task automatic t_release();
    uv_clear = 1'b1;
    tick(1);
    chk("R3", "released", uv_locked, 1'b0);
    chk("R5", "no out on release", hi_out, 1'b0);
    uv_clear = 1'b0;
    tick(4);
    chk("R5", "held cmd ignored", hi_out, 1'b0);
    hi_cmd = 1'b0; tick(1);
    hi_cmd = 1'b1; tick(1);
    chk("R5", "fresh edge enables", hi_out, 1'b1);
    hi_cmd = 1'b0; tick(1);
    chk("R5", "follows low", hi_out, 1'b0);
    hi_cmd = 1'b1; tick(1);
    chk("R5", "follows high", hi_out, 1'b1);
  endtask

  task automatic t_glitch();
    for (int k = 0; k < 3; k++) begin
      uv_trip = 1'b1; tick(F);
      chk("R2", "short run no lock", uv_locked, 1'b0);
      uv_trip = 1'b0; tick(1);
    end
    chk("R2", "hi passes after dips", hi_out, 1'b1);
  endtask

  task automatic t_lock();
    uv_trip = 1'b1;
    tick(F);
    chk("R1", "not yet locked", uv_locked, 1'b0);
    chk("R1", "hi still on", hi_out, 1'b1);
    tick(1);
    chk("R1", "locked after filter", uv_locked, 1'b1);
    chk("R4", "hi forced low", hi_out, 1'b0);
    uv_trip = 1'b0;
    lo_cmd = 1'b1; tick(1);
    chk("R6", "lo high while locked", lo_out, 1'b1);
    lo_cmd = 1'b0; tick(1);
    chk("R6", "lo low while locked", lo_out, 1'b0);
    chk("R4", "locked persists", uv_locked, 1'b1);
  endtask

  task automatic t_conflict();
    uv_trip = 1'b1; uv_clear = 1'b1;
    tick(3);
    chk("R7", "conflict holds lock", uv_locked, 1'b1);
    uv_trip = 1'b0; tick(1);
    chk("R3", "release after conflict", uv_locked, 1'b0);
    chk("R5", "held cmd after release", hi_out, 1'b0);
    uv_clear = 1'b0;
    uv_trip = 1'b1; tick(F - 2);
    uv_clear = 1'b1; tick(3 * F);
    chk("R7", "conflict holds unlocked", uv_locked, 1'b0);
    uv_clear = 1'b0; tick(2);
    chk("R7", "count kept through conflict", uv_locked, 0);
    tick(1);
    chk("R7", "locks on kept count", uv_locked, 1'b1);
    uv_trip = 1'b0; uv_clear = 1'b1; tick(1);
    uv_clear = 1'b0;
    hi_cmd = 1'b0; tick(1);
    hi_cmd = 1'b1; tick(1);
    chk("R5", "edge after relock", hi_out, 1'b1);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_release();
    t_glitch();
    t_lock();
    t_conflict();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule